// File: doc/BRIEF.md
# Boot ROM Data-Bus Patcher

This block overrides one boot ROM data line for a few clock cycles at one chosen moment during system boot, and then releases the line. It does not decode addresses. It finds the moment from activity on one or two ROM address lines. After a start pulse, it first lines up with a rising edge on the primary address line (AX). It then counts quiet windows, which are stretches in which AX stays low for a programmed number of cycles. Next it counts address pulses. On the last counted pulse it waits a programmed offset, enables its data driver for a programmed length, and returns the line to high impedance.

An optional second phase repeats the quiet-window search on AX with its own target. It then counts falling edges of the secondary address line (AY) and performs a second override with its own offset and length. An active-low bypass switch skips the whole sequence. Address lines and the switch cross into the clock domain through two-flop synchronizers. Every offset and length is measured in system-clock cycles from the synchronized edge.

Top module: `rom_patch_ctrl`

## Requirements
- R1: When `start_i` is seen while `bypass_ni` reads low, the block performs no override. `phase_o` becomes 3 and `busy_o` stays low, whatever AX and AY do afterwards.
- R2: If AX is high at start, the block waits for AX to fall and then rise before the quiet search. If AX is low, it waits only for the next rise. A level with no such edge never advances it.
- R3: A quiet window is credited only after `quiet_len_i` consecutive low AX samples. A high sample abandons the current window and restarts it once AX is low again. Credits earned earlier are kept. Arming happens when the credits reach the phase target (target 0 acts as 1).
- R4: In phase one, rising AX edges are counted once armed. The override starts from the edge that reaches `pulse_tgt1_i` (0 acts as 1). No earlier edge enables the driver.
- R5: `data_oe_o` first reads high exactly 3 + offset cycles after the cycle in which the counting input edge is applied. It stays high for exactly the hold count (0 acts as 1), then drops, and it is never high at any other time.
- R6: `data_o` is low except while `data_oe_o` is high during the first override with `two_phase_i` set, when it is high.
- R7: With `two_phase_i` set, the first override is followed by a quiet search on AX against `quiet_tgt2_i`. Then only falling AY edges are counted to `pulse_tgt2_i`. Rising AY edges and AX edges are ignored, and the second override uses `offset2_i` and `hold2_i`.
- R8: `phase_o` is 0 while idle or running, 1 after the first override, 2 after the second, and 3 after a bypass. A new start clears it.
- R9: `busy_o` is high from arming until the end of each override and low otherwise.
- R10: Reset forces `data_oe_o`, `data_o`, `busy_o` and `phase_o` to 0 immediately, and the block waits for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a patch sequence (accepted when idle or finished) |
| bypass_ni | input | 1 | Patch-disable switch, low skips patching (pulled up on board) |
| two_phase_i | input | 1 | Enable the second override phase |
| ax_i | input | 1 | Primary ROM address line |
| ay_i | input | 1 | Secondary ROM address line |
| quiet_len_i | input | QW | Low samples forming one quiet window |
| quiet_tgt1_i | input | CW | Quiet windows needed before phase one |
| quiet_tgt2_i | input | CW | Quiet windows needed before phase two |
| pulse_tgt1_i | input | PW | Rising AX edges counted in phase one |
| pulse_tgt2_i | input | PW | Falling AY edges counted in phase two |
| offset1_i | input | TW | Cycles from final edge to drive, phase one |
| hold1_i | input | TW | Drive length, phase one |
| offset2_i | input | TW | Cycles from final edge to drive, phase two |
| hold2_i | input | TW | Drive length, phase two |
| data_o | output | 1 | Data-line drive value |
| data_oe_o | output | 1 | Data-line output enable |
| busy_o | output | 1 | Armed or overriding (LED) |
| phase_o | output | 2 | Progress status code |

## Verification
Most internal faults appear first at `data_oe_o`. A wrong pulse or window count, or a lost quiet credit, moves the first enabled cycle away from the edge-plus-offset position, or removes the override altogether. The bench measures that first cycle to the clock against the input edge. A wrong quiet count or alignment state shows up earlier on `busy_o`, which rises at the wrong moment or never rises. Phase sequencing faults show in `phase_o` one cycle after an override ends, and also in the level of `data_o` while the driver is enabled.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ALN_FALL, S_ALN_RISE, S_QUIET, S_ARM, S_OFFSET, S_DRIVE, S_DONE
  } rpc_state_e;

  localparam logic [1:0] PH_RUN = 2'd0;
  localparam logic [1:0] PH_ONE = 2'd1;
  localparam logic [1:0] PH_TWO = 2'd2;
  localparam logic [1:0] PH_BYP = 2'd3;
endpackage

// File: rtl/rpc_sync.sv
module rpc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rst_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[0] <= rst_val_i;
        else         st_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= rst_val_i;
        else         st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/rpc_downcnt.sv
module rpc_downcnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= val_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - W'(1);

  assign last_o = (cnt_q <= W'(1));
endmodule

// File: rtl/rpc_quiet.sv
module rpc_quiet #(
  parameter int QW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          line_i,
  input  logic [QW-1:0] len_i,
  input  logic [CW-1:0] tgt_i,
  output logic          done_o
);
  logic [QW-1:0] cnt_q;
  logic [CW-1:0] conf_q;
  logic          wait_q;
  logic          win_end;
  logic [CW:0]   conf_next;
  logic [CW:0]   tgt_eff;

  assign win_end   = run_i && !wait_q && !line_i && (cnt_q <= QW'(1));
  assign conf_next = {1'b0, conf_q} + (CW+1)'(1);
  assign tgt_eff   = (tgt_i == '0) ? (CW+1)'(1) : {1'b0, tgt_i};
  assign done_o    = win_end && (conf_next >= tgt_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      conf_q <= '0;
      wait_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= len_i;
      conf_q <= '0;
      wait_q <= 1'b0;
    end else if (run_i) begin
      if (wait_q) begin
        if (!line_i) begin
          wait_q <= 1'b0;
          cnt_q  <= len_i;
        end
      end else if (line_i) begin
        wait_q <= 1'b1;               // abandon window, credits kept
      end else if (win_end) begin
        conf_q <= conf_next[CW-1:0];
        cnt_q  <= len_i;
      end else begin
        cnt_q  <= cnt_q - QW'(1);
      end
    end
  end

  // R3
  credit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> ((conf_q - $past(conf_q)) <= CW'(1)));
endmodule

// File: rtl/rom_patch_ctrl.sv
module rom_patch_ctrl
  import rpc_pkg::*;
#(
  parameter int QW     = 16,
  parameter int CW     = 8,
  parameter int PW     = 8,
  parameter int TW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          bypass_ni,
  input  logic          two_phase_i,
  input  logic          ax_i,
  input  logic          ay_i,
  input  logic [QW-1:0] quiet_len_i,
  input  logic [CW-1:0] quiet_tgt1_i,
  input  logic [CW-1:0] quiet_tgt2_i,
  input  logic [PW-1:0] pulse_tgt1_i,
  input  logic [PW-1:0] pulse_tgt2_i,
  input  logic [TW-1:0] offset1_i,
  input  logic [TW-1:0] hold1_i,
  input  logic [TW-1:0] offset2_i,
  input  logic [TW-1:0] hold2_i,
  output logic          data_o,
  output logic          data_oe_o,
  output logic          busy_o,
  output logic [1:0]    phase_o
);
  localparam int NSYNC = 3;

  rpc_state_e  state_q, state_d;
  logic [1:0]  phase_q, phase_d;
  logic        second_q, second_d;
  logic [NSYNC-1:0] sync_o;
  logic        ax_s, ay_s, sw_s, ax_q, ay_q;
  logic        ax_rise, ay_fall, cnt_edge;
  logic        q_clr, q_done;
  logic        p_load, p_dec, p_last;
  logic        t_load, t_dec, t_last;
  logic [PW-1:0] p_val;
  logic [TW-1:0] t_val, off_sel, hold_sel, hold_eff;

  rpc_sync #(.W(NSYNC), .STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i      ({bypass_ni, ay_i, ax_i}),
    .rst_val_i(3'b100),
    .q_o      (sync_o)
  );
  assign {sw_s, ay_s, ax_s} = sync_o;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ax_q <= 1'b0;
      ay_q <= 1'b0;
    end else begin
      ax_q <= ax_s;
      ay_q <= ay_s;
    end

  assign ax_rise  = ax_s && !ax_q;
  assign ay_fall  = !ay_s && ay_q;
  assign cnt_edge = second_q ? ay_fall : ax_rise;

  rpc_quiet #(.QW(QW), .CW(CW)) u_quiet (
    .clk_i, .rst_ni,
    .clr_i (q_clr),
    .run_i (state_q == S_QUIET),
    .line_i(ax_s),
    .len_i (quiet_len_i),
    .tgt_i (second_q ? quiet_tgt2_i : quiet_tgt1_i),
    .done_o(q_done)
  );

  rpc_downcnt #(.W(PW)) u_pulse (
    .clk_i, .rst_ni,
    .load_i(p_load), .val_i(p_val), .dec_i(p_dec), .last_o(p_last)
  );

  rpc_downcnt #(.W(TW)) u_time (
    .clk_i, .rst_ni,
    .load_i(t_load), .val_i(t_val), .dec_i(t_dec), .last_o(t_last)
  );

  assign off_sel  = second_q ? offset2_i : offset1_i;
  assign hold_sel = second_q ? hold2_i : hold1_i;
  assign hold_eff = (hold_sel == '0) ? TW'(1) : hold_sel;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    second_d = second_q;
    q_clr    = 1'b0;
    p_load   = 1'b0;
    p_dec    = 1'b0;
    p_val    = second_q ? pulse_tgt2_i : pulse_tgt1_i;
    t_load   = 1'b0;
    t_dec    = 1'b0;
    t_val    = hold_eff;
    unique case (state_q)
      S_IDLE, S_DONE: begin
        if (start_i) begin
          second_d = 1'b0;
          if (!sw_s) begin
            phase_d = PH_BYP;
            state_d = S_DONE;
          end else begin
            phase_d = PH_RUN;
            state_d = ax_s ? S_ALN_FALL : S_ALN_RISE;
          end
        end
      end
      S_ALN_FALL: if (!ax_s) state_d = S_ALN_RISE;
      S_ALN_RISE: begin
        if (ax_rise) begin
          q_clr   = 1'b1;
          state_d = S_QUIET;
        end
      end
      S_QUIET: begin
        if (q_done) begin
          p_load  = 1'b1;
          state_d = S_ARM;
        end
      end
      S_ARM: begin
        if (cnt_edge) begin
          if (p_last) begin
            t_load = 1'b1;
            if (off_sel == '0) state_d = S_DRIVE;
            else begin
              t_val   = off_sel;
              state_d = S_OFFSET;
            end
          end else begin
            p_dec = 1'b1;
          end
        end
      end
      S_OFFSET: begin
        if (t_last) begin
          t_load  = 1'b1;
          state_d = S_DRIVE;
        end else begin
          t_dec = 1'b1;
        end
      end
      S_DRIVE: begin
        if (t_last) begin
          if (!second_q) begin
            phase_d = PH_ONE;
            if (two_phase_i) begin
              second_d = 1'b1;
              q_clr    = 1'b1;
              state_d  = S_QUIET;
            end else begin
              state_d = S_DONE;
            end
          end else begin
            phase_d = PH_TWO;
            state_d = S_DONE;
          end
        end else begin
          t_dec = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      phase_q  <= PH_RUN;
      second_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      second_q <= second_d;
    end

  assign data_oe_o = (state_q == S_DRIVE);
  assign data_o    = data_oe_o && two_phase_i && !second_q;
  assign busy_o    = (state_q == S_ARM) || (state_q == S_OFFSET) || (state_q == S_DRIVE);
  assign phase_o   = phase_q;

  // R5
  oe_after_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $past(busy_o));

  // R6
  drive_high_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o |-> (data_oe_o && two_phase_i && phase_o == PH_RUN));

  // R8
  phase_one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_ONE && $past(phase_o) == PH_RUN) |-> ($past(data_oe_o) && !data_oe_o));

  // R1
  bypass_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_BYP) |-> (!busy_o && !data_oe_o));

  // R9
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(data_oe_o));
endmodule

// File: tb/rom_patch_ctrl_tb.sv
module rom_patch_ctrl_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, bypass_ni = 1, two_phase_i = 0, ax_i = 0, ay_i = 0;
  logic [15:0] quiet_len_i = 16'd4;
  logic [7:0]  quiet_tgt1_i = 8'd3, quiet_tgt2_i = 8'd2;
  logic [7:0]  pulse_tgt1_i = 8'd1, pulse_tgt2_i = 8'd2;
  logic [7:0]  offset1_i = 0, hold1_i = 1, offset2_i = 0, hold2_i = 1;
  logic data_o, data_oe_o, busy_o;
  logic [1:0] phase_o;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int oe_cnt = 0, dhi = 0, first_hi = -1;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (data_oe_o) begin
    oe_cnt++;
    if (data_o) dhi++;
    if (first_hi < 0) first_hi = cyc;
  end

  rom_patch_ctrl u_dut (
    .clk_i(clk), .rst_ni, .start_i, .bypass_ni, .two_phase_i, .ax_i, .ay_i,
    .quiet_len_i, .quiet_tgt1_i, .quiet_tgt2_i, .pulse_tgt1_i, .pulse_tgt2_i,
    .offset1_i, .hold1_i, .offset2_i, .hold2_i,
    .data_o, .data_oe_o, .busy_o, .phase_o
  );

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask
  task automatic clr_mon(); oe_cnt = 0; dhi = 0; first_hi = -1; endtask
  task automatic start_run(); @(negedge clk); start_i = 1; @(negedge clk); start_i = 0; endtask
  task automatic ax_pulse(int low_after);
    @(negedge clk); ax_i = 1; @(negedge clk); ax_i = 0; tick(low_after);
  endtask

  task automatic run_single(int off, int hold, int np);
    int c;
    @(negedge clk);
    two_phase_i = 0; offset1_i = 8'(off); hold1_i = 8'(hold); pulse_tgt1_i = 8'(np);
    clr_mon();
    start_run();
    tick(3);
    ax_pulse(30);
    chk(busy_o == 1, "R9", "busy armed", busy_o, 1);
    chk(phase_o == 0, "R8", "phase running", phase_o, 0);
    for (int i = 0; i < np - 1; i++) ax_pulse(3);
    chk(oe_cnt == 0, "R4", "no early drive", oe_cnt, 0);
    @(negedge clk); c = cyc; ax_i = 1; @(negedge clk); ax_i = 0;
    tick(off + hold + 10);
    chk(first_hi == c + 3 + off, "R5", "first drive cycle", first_hi, c + 3 + off);
    chk(oe_cnt == ((hold == 0) ? 1 : hold), "R5", "drive length", oe_cnt, (hold == 0) ? 1 : hold);
    chk(dhi == 0, "R6", "single-phase value low", dhi, 0);
    chk(phase_o == 1, "R8", "phase after override", phase_o, 1);
    chk(busy_o == 0, "R9", "busy cleared", busy_o, 0);
  endtask

  initial begin
    int c;
    tick(3);
    chk(data_oe_o == 0 && data_o == 0, "R10", "reset drive", data_oe_o, 0);
    chk(busy_o == 0, "R10", "reset busy", busy_o, 0);
    chk(phase_o == 0, "R10", "reset phase", phase_o, 0);
    @(negedge clk); rst_ni = 1;
    tick(3);

    // R1 bypass
    bypass_ni = 0; tick(4); clr_mon();
    start_run(); tick(3);
    chk(phase_o == 3, "R1", "bypass phase code", phase_o, 3);
    for (int i = 0; i < 6; i++) ax_pulse(8);
    chk(oe_cnt == 0, "R1", "bypass no drive", oe_cnt, 0);
    chk(busy_o == 0, "R1", "bypass not busy", busy_o, 0);
    bypass_ni = 1; tick(4);

    // R4 R5 R6 sweep
    for (int o = 0; o < 4; o++)
      for (int h = 0; h < 3; h++)
        for (int p = 1; p <= 3; p++)
          run_single((o == 3) ? 5 : o, (h == 2) ? 3 : h, (p == 3) ? 4 : p);

    // R2 alignment with AX high at start
    pulse_tgt1_i = 1; offset1_i = 1; hold1_i = 2; clr_mon();
    @(negedge clk); ax_i = 1; tick(4);
    start_run(); tick(40);
    chk(busy_o == 0, "R2", "held high no arm", busy_o, 0);
    @(negedge clk); ax_i = 0; tick(40);
    chk(busy_o == 0, "R2", "fall only no arm", busy_o, 0);
    ax_pulse(30);
    chk(busy_o == 1, "R2", "armed after fall then rise", busy_o, 1);
    ax_pulse(12);
    chk(oe_cnt == 2, "R2", "override after alignment", oe_cnt, 2);

    // R3 quiet windows: short gaps never credit, long gaps credit one each
    clr_mon(); start_run(); tick(3);
    for (int i = 0; i < 15; i++) ax_pulse(2);
    chk(busy_o == 0, "R3", "short gaps no arm", busy_o, 0);
    ax_pulse(7); ax_pulse(7);
    chk(busy_o == 0, "R3", "two credits not enough", busy_o, 0);
    ax_pulse(7);
    chk(busy_o == 1, "R3", "third credit arms", busy_o, 1);
    chk(oe_cnt == 0, "R3", "no drive yet", oe_cnt, 0);
    ax_pulse(12);
    chk(phase_o == 1, "R3", "completes", phase_o, 1);

    // R7 two-phase
    @(negedge clk);
    two_phase_i = 1; pulse_tgt1_i = 1; offset1_i = 2; hold1_i = 3;
    pulse_tgt2_i = 2; offset2_i = 1; hold2_i = 2; ay_i = 0;
    clr_mon(); start_run(); tick(3);
    ax_pulse(30);
    ax_pulse(12);
    chk(oe_cnt == 3, "R7", "first override length", oe_cnt, 3);
    chk(dhi == 3, "R6", "first override value high", dhi, 3);
    chk(phase_o == 1, "R8", "phase one", phase_o, 1);
    tick(20);
    chk(busy_o == 1, "R9", "re-armed for phase two", busy_o, 1);
    clr_mon();
    for (int i = 0; i < 3; i++) ax_pulse(4);
    @(negedge clk); ay_i = 1; tick(6);
    chk(oe_cnt == 0, "R7", "AX and AY rise ignored", oe_cnt, 0);
    @(negedge clk); ay_i = 0; tick(5);
    @(negedge clk); ay_i = 1; tick(5);
    chk(oe_cnt == 0, "R7", "first AY fall not final", oe_cnt, 0);
    @(negedge clk); c = cyc; ay_i = 0;
    tick(12);
    chk(first_hi == c + 4, "R7", "second drive cycle", first_hi, c + 4);
    chk(oe_cnt == 2, "R7", "second drive length", oe_cnt, 2);
    chk(dhi == 0, "R6", "second override value low", dhi, 0);
    chk(phase_o == 2, "R8", "phase two", phase_o, 2);
    chk(busy_o == 0, "R9", "busy cleared after second", busy_o, 0);

    // R10 reset during drive
    @(negedge clk); two_phase_i = 0; offset1_i = 0; hold1_i = 20; clr_mon();
    start_run(); tick(3); ax_pulse(30);
    @(negedge clk); ax_i = 1; @(negedge clk); ax_i = 0; tick(5);
    chk(data_oe_o == 1, "R10", "driving before reset", data_oe_o, 1);
    rst_ni = 0; #1;
    chk(data_oe_o == 0, "R10", "reset releases line", data_oe_o, 0);
    chk(busy_o == 0 && phase_o == 0, "R10", "reset clears status", phase_o, 0);
    tick(2); rst_ni = 1; tick(2);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule